// File: doc/BRIEF.md
# Parallel Panel Timing Generator with Deferred Geometry Commit

This block produces horizontal sync, vertical sync, data-enable, pixel coordinates and a pixel colour bus for a parallel TFT panel. A small word-wide register port programs it. Panel size, porches, sync widths and pin polarity are written into a shadow set. The shadow set drives nothing until software requests a commit. The commit takes effect at the boundary between two frames, so a displayed frame is never drawn with a mix of old and new geometry.

Each line is laid out as sync pulse, back porch, active pixels and front porch. A frame is laid out the same way in lines. Upstream pixel logic uses the x/y outputs and returns a pixel word with a valid flag. When that flag is low, or outside the active window, the block drives a programmable background colour instead. The colour is packed to the selected bus width. The pixel clock, pixel fetch and blending are not part of this block.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the registers read back as follows. Control reads 0. Size holds the parameter defaults minus one. Horizontal timing is back porch 47, front porch 15 and sync 95. Vertical timing is back porch 32, front porch 9 and sync 2. Polarity reads 0. Background reads 0x00FF0000. Register addresses are 0 control, 1 size, 2 horizontal timing, 3 vertical timing, 4 polarity and 5 background.
- R2: The size word holds active width minus one in bits 11:0 and active height minus one in bits 27:16. Each timing word holds back porch in bits 31:20, front porch in bits 19:8 and sync width in bits 7:0. A read returns the most recently written shadow value.
- R3: A line lasts sync + back porch + width + front porch clocks, and a frame lasts the vertical counterpart in lines. Porch and sync fields are plain counts, while size fields are minus one.
- R4: Horizontal sync is active for the first sync-width clocks of each line. Vertical sync is active during the first sync-width lines of the frame. Data-enable is never active together with horizontal sync.
- R5: Data-enable is active only where both the horizontal and the vertical counts are inside the active window. There, x and y count from 0. Outside the window both read 0.
- R6: The colour bus carries the pixel input when data-enable is active and the valid input is high. Otherwise it carries the background colour, which takes effect as soon as it is written.
- R7: Control bit 0 enables scanning. Bit 3 stores the TFT mode flag. Bits 9:8 pick the packing, always LSB-aligned: 3 is 24-bit; 2 is 18-bit (6 MSBs of each channel); 1 is 16-bit (5/6/5 MSBs); 0 is 12-bit (4 MSBs each). Control bits act immediately.
- R8: Polarity bit 0 inverts horizontal sync, bit 1 inverts vertical sync and bit 2 inverts data-enable. A value of 0 means active-high. Each output pin uses the polarity of the configuration that produced that output cycle.
- R9: Writing control with bit 5 set raises the GO flag, which reads back as 1 while it is pending. Hardware alone clears it, in the cycle where the commit happens.
- R10: While scanning, a pending commit happens only on the last clock of a frame. The next frame starts with the new set. Shadow writes made while GO is pending are still accepted and are included in the commit.
- R11: While disabled, the counters are held at the frame start and the outputs rest at their inactive levels, with x and y at 0. A pending GO completes on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| pix_valid_i | input | 1 | Pixel input is valid this cycle |
| pix_data_i | input | 24 | Pixel input, 8:8:8 RGB |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data-enable after polarity |
| x_o | output | 12 | Column inside the active window |
| y_o | output | 12 | Row inside the active window |
| rgb_o | output | 24 | Packed colour bus |

## Verification
The sync, enable and coordinate outputs are registered. They reflect the counter position of the previous clock, so each result falls due one clock after the counter reaches that position. The bench aligns once on the first vertical sync edge and then predicts every output, every cycle, from an arithmetic model indexed by cycles since that edge. It samples on the falling edge. The colour bus is combinational on the registered enable and the pixel inputs, so it is checked in the same sample as the value driven at the previous falling edge. A GO commit issued mid-frame must leave the remaining cycles of that frame matching the old geometry, and the frame that follows must match the new one with no gap.

// File: rtl/lcdt_pkg.sv
// Shared field widths, register indices, bit positions and the colour
// packing function of the panel timing generator.
package lcdt_pkg;
    localparam int SZ_W    = 12;   // size field width (minus-one coded)
    localparam int SYN_W   = 8;    // sync width field
    localparam int POR_W   = 12;   // porch fields
    localparam int CNT_W   = 15;   // counter width, holds the largest sum
    localparam int RGB_W   = 24;
    localparam int AD_W    = 3;
    localparam int DW      = 32;

    localparam logic [AD_W-1:0] A_CTRL = 3'd0;
    localparam logic [AD_W-1:0] A_SIZE = 3'd1;
    localparam logic [AD_W-1:0] A_HTIM = 3'd2;
    localparam logic [AD_W-1:0] A_VTIM = 3'd3;
    localparam logic [AD_W-1:0] A_POL  = 3'd4;
    localparam logic [AD_W-1:0] A_BG   = 3'd5;

    localparam int C_EN  = 0;
    localparam int C_TFT = 3;
    localparam int C_GO  = 5;
    localparam int C_FMT = 8;
    localparam int SIZE_V_LSB = 16;
    localparam int T_FP_LSB   = 8;
    localparam int T_BP_LSB   = 20;

    typedef struct packed {
        logic [POR_W-1:0] bp;
        logic [POR_W-1:0] fp;
        logic [SYN_W-1:0] sw;
        logic [SZ_W-1:0]  act_m1;
    } axis_t;

    typedef struct packed {
        axis_t      h;
        axis_t      v;
        logic [2:0] pol;
    } geom_t;

    // Pack an 8:8:8 colour to the selected LSB-aligned bus width.
    function automatic logic [RGB_W-1:0] pack_rgb(input logic [1:0] f, input logic [RGB_W-1:0] c);
        case (f)
            2'd3:    pack_rgb = c;
            2'd2:    pack_rgb = {6'b0, c[23:18], c[15:10], c[7:2]};
            2'd1:    pack_rgb = {8'b0, c[23:19], c[15:10], c[7:3]};
            default: pack_rgb = {12'b0, c[23:20], c[15:12], c[7:4]};
        endcase
    endfunction
endpackage

// File: rtl/lcdt_regs.sv
// Register bank: live control and background colour, a shadow geometry set,
// and the active geometry set loaded from the shadow on commit.
// Assumes frame_end_i is high only on the final clock of a scanned frame.
module lcdt_regs import lcdt_pkg::*; #(
    parameter int DEF_W   = 1024,
    parameter int DEF_H   = 768,
    parameter int DEF_HBP = 47,
    parameter int DEF_HFP = 15,
    parameter int DEF_HSW = 95,
    parameter int DEF_VBP = 32,
    parameter int DEF_VFP = 9,
    parameter int DEF_VSW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [AD_W-1:0]  addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    input  logic             frame_end_i,
    output geom_t            act_o,
    output logic             en_o,
    output logic [1:0]       fmt_o,
    output logic [RGB_W-1:0] bg_o
);
    localparam geom_t DEF_G = '{
        h: '{bp: POR_W'(DEF_HBP), fp: POR_W'(DEF_HFP), sw: SYN_W'(DEF_HSW), act_m1: SZ_W'(DEF_W - 1)},
        v: '{bp: POR_W'(DEF_VBP), fp: POR_W'(DEF_VFP), sw: SYN_W'(DEF_VSW), act_m1: SZ_W'(DEF_H - 1)},
        pol: 3'b000
    };

    geom_t            sh_q, act_q;
    logic             en_q, tft_q, go_q;
    logic [1:0]       fmt_q;
    logic [RGB_W-1:0] bg_q;
    logic             wr_ctrl, commit;

    assign wr_ctrl = we_i && (addr_i == A_CTRL);
    assign commit  = go_q && (!en_q || frame_end_i);

    // Shadow geometry: written by software at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= DEF_G;
        end else if (we_i) begin
            case (addr_i)
                A_SIZE: begin
                    sh_q.h.act_m1 <= wdata_i[SZ_W-1:0];
                    sh_q.v.act_m1 <= wdata_i[SIZE_V_LSB +: SZ_W];
                end
                A_HTIM: begin
                    sh_q.h.bp <= wdata_i[T_BP_LSB +: POR_W];
                    sh_q.h.fp <= wdata_i[T_FP_LSB +: POR_W];
                    sh_q.h.sw <= wdata_i[SYN_W-1:0];
                end
                A_VTIM: begin
                    sh_q.v.bp <= wdata_i[T_BP_LSB +: POR_W];
                    sh_q.v.fp <= wdata_i[T_FP_LSB +: POR_W];
                    sh_q.v.sw <= wdata_i[SYN_W-1:0];
                end
                A_POL:   sh_q.pol <= wdata_i[2:0];
                default: ;
            endcase
        end
    end

    // Live control and background colour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            tft_q <= 1'b0;
            fmt_q <= 2'd0;
            bg_q  <= 24'hFF0000;
        end else begin
            if (wr_ctrl) begin
                en_q  <= wdata_i[C_EN];
                tft_q <= wdata_i[C_TFT];
                fmt_q <= wdata_i[C_FMT +: 2];
            end
            if (we_i && addr_i == A_BG) bg_q <= wdata_i[RGB_W-1:0];
        end
    end

    // GO flag: a write sets it, a commit clears it; a new request wins.
    always_ff @(posedge clk) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= (go_q && !commit) || (wr_ctrl && wdata_i[C_GO]);
    end

    // Active set: loaded from the shadow only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= DEF_G;
        else if (commit) act_q <= sh_q;
    end

    // Read mux over the software-visible view.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: begin
                rdata_o[C_EN]       = en_q;
                rdata_o[C_TFT]      = tft_q;
                rdata_o[C_GO]       = go_q;
                rdata_o[C_FMT +: 2] = fmt_q;
            end
            A_SIZE: begin
                rdata_o[SZ_W-1:0]          = sh_q.h.act_m1;
                rdata_o[SIZE_V_LSB +: SZ_W] = sh_q.v.act_m1;
            end
            A_HTIM:  rdata_o = {sh_q.h.bp, sh_q.h.fp, sh_q.h.sw};
            A_VTIM:  rdata_o = {sh_q.v.bp, sh_q.v.fp, sh_q.v.sw};
            A_POL:   rdata_o[2:0] = sh_q.pol;
            A_BG:    rdata_o[RGB_W-1:0] = bg_q;
            default: rdata_o = '0;
        endcase
    end

    assign act_o = act_q;
    assign en_o  = en_q;
    assign fmt_o = fmt_q;
    assign bg_o  = bg_q;

    // R10
    act_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_q) && !$past(frame_end_i)) |-> $stable(act_q));
    // R9
    go_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_q) |-> $past(we_i && addr_i == A_CTRL && wdata_i[C_GO]));
    // R9
    go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go_q) |-> $past(!en_q || frame_end_i));
endmodule

// File: rtl/lcdt_axis_dec.sv
// Decodes one scan axis: sync region, active window, position in the
// window and the last count of the period. Combinational.
// Assumes the count never passes the period's last value.
module lcdt_axis_dec import lcdt_pkg::*; (
    input  logic [CNT_W-1:0] cnt_i,
    input  axis_t            ax_i,
    output logic             sync_o,
    output logic             act_o,
    output logic [SZ_W-1:0]  pos_o,
    output logic             last_o
);
    logic [CNT_W-1:0] a_start, a_stop, t_last;

    // Region boundaries from plain-count porches and minus-one size.
    always_comb begin
        a_start = CNT_W'(ax_i.sw) + CNT_W'(ax_i.bp);
        a_stop  = a_start + CNT_W'(ax_i.act_m1) + CNT_W'(1);
        t_last  = a_stop + CNT_W'(ax_i.fp) - CNT_W'(1);
    end

    assign sync_o = cnt_i < CNT_W'(ax_i.sw);
    assign act_o  = (cnt_i >= a_start) && (cnt_i < a_stop);
    assign pos_o  = act_o ? SZ_W'(cnt_i - a_start) : '0;
    assign last_o = (cnt_i == t_last);
endmodule

// File: rtl/lcdt_scan.sv
// Pixel and line counters. Held at the frame origin while disabled.
// Assumes h_last_i and v_last_i come from decoders of the same counts.
module lcdt_scan import lcdt_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             h_last_i,
    input  logic             v_last_i,
    output logic [CNT_W-1:0] hc_o,
    output logic [CNT_W-1:0] vc_o,
    output logic             frame_end_o
);
    // Advance the pixel count, wrap into the next line and frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            hc_o <= '0;
            vc_o <= '0;
        end else if (h_last_i) begin
            hc_o <= '0;
            vc_o <= v_last_i ? '0 : vc_o + CNT_W'(1);
        end else begin
            hc_o <= hc_o + CNT_W'(1);
        end
    end

    assign frame_end_o = en_i && h_last_i && v_last_i;

    // R3
    line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && en_i && hc_o == '0 && $past(hc_o) != '0) |-> $past(h_last_i));
endmodule

// File: rtl/lcdt_out.sv
// Output stage: registers sync, enable and coordinates, applies the
// polarity of the configuration that produced each cycle, packs colour.
// Assumes the decoded inputs describe the current counter position.
module lcdt_out import lcdt_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             hs_i,
    input  logic             vs_i,
    input  logic             de_i,
    input  logic [SZ_W-1:0]  x_i,
    input  logic [SZ_W-1:0]  y_i,
    input  logic [2:0]       pol_i,
    input  logic [1:0]       fmt_i,
    input  logic [RGB_W-1:0] bg_i,
    input  logic             pix_valid_i,
    input  logic [RGB_W-1:0] pix_data_i,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [SZ_W-1:0]  x_o,
    output logic [SZ_W-1:0]  y_o,
    output logic [RGB_W-1:0] rgb_o
);
    logic            hs_q, vs_q, de_q;
    logic [2:0]      pol_q;
    logic [SZ_W-1:0] x_q, y_q;

    // Register the decoded position together with its polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q  <= 1'b0;
            vs_q  <= 1'b0;
            de_q  <= 1'b0;
            x_q   <= '0;
            y_q   <= '0;
            pol_q <= 3'b000;
        end else begin
            hs_q  <= en_i && hs_i;
            vs_q  <= en_i && vs_i;
            de_q  <= en_i && de_i;
            x_q   <= (en_i && de_i) ? x_i : '0;
            y_q   <= (en_i && de_i) ? y_i : '0;
            pol_q <= pol_i;
        end
    end

    assign hsync_o = hs_q ^ pol_q[0];
    assign vsync_o = vs_q ^ pol_q[1];
    assign de_o    = de_q ^ pol_q[2];
    assign x_o     = x_q;
    assign y_o     = y_q;
    assign rgb_o   = pack_rgb(fmt_i, (de_q && pix_valid_i) ? pix_data_i : bg_i);

    // R4
    de_hs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_q |-> !hs_q);
    // R5
    coord_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de_q |-> (x_q == '0 && y_q == '0));
    // R11
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (!de_q && !hs_q && !vs_q));
endmodule

// File: rtl/lcd_timing_gen.sv
// Top level: register bank, two axis decoders, counters and output stage.
// Assumes a single clock domain (the pixel clock) for register access.
module lcd_timing_gen import lcdt_pkg::*; #(
    parameter int DEF_W   = 1024,
    parameter int DEF_H   = 768,
    parameter int DEF_HBP = 47,
    parameter int DEF_HFP = 15,
    parameter int DEF_HSW = 95,
    parameter int DEF_VBP = 32,
    parameter int DEF_VFP = 9,
    parameter int DEF_VSW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [AD_W-1:0]  reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             pix_valid_i,
    input  logic [RGB_W-1:0] pix_data_i,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [SZ_W-1:0]  x_o,
    output logic [SZ_W-1:0]  y_o,
    output logic [RGB_W-1:0] rgb_o
);
    localparam int N_AX = 2;   // 0 horizontal, 1 vertical

    geom_t            act;
    logic             en, frame_end;
    logic [1:0]       fmt;
    logic [RGB_W-1:0] bg;
    logic [CNT_W-1:0] hc, vc;

    axis_t            ax_sel  [N_AX];
    logic [CNT_W-1:0] cnt_sel [N_AX];
    logic             sync_w  [N_AX];
    logic             act_w   [N_AX];
    logic             last_w  [N_AX];
    logic [SZ_W-1:0]  pos_w   [N_AX];

    lcdt_regs #(
        .DEF_W(DEF_W), .DEF_H(DEF_H),
        .DEF_HBP(DEF_HBP), .DEF_HFP(DEF_HFP), .DEF_HSW(DEF_HSW),
        .DEF_VBP(DEF_VBP), .DEF_VFP(DEF_VFP), .DEF_VSW(DEF_VSW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
        .frame_end_i(frame_end),
        .act_o(act), .en_o(en), .fmt_o(fmt), .bg_o(bg)
    );

    assign ax_sel[0]  = act.h;
    assign ax_sel[1]  = act.v;
    assign cnt_sel[0] = hc;
    assign cnt_sel[1] = vc;

    for (genvar a = 0; a < N_AX; a++) begin : g_axis
        lcdt_axis_dec u_dec (
            .cnt_i(cnt_sel[a]), .ax_i(ax_sel[a]),
            .sync_o(sync_w[a]), .act_o(act_w[a]), .pos_o(pos_w[a]), .last_o(last_w[a])
        );
    end

    lcdt_scan u_scan (
        .clk(clk), .rst_n(rst_n), .en_i(en),
        .h_last_i(last_w[0]), .v_last_i(last_w[1]),
        .hc_o(hc), .vc_o(vc), .frame_end_o(frame_end)
    );

    lcdt_out u_out (
        .clk(clk), .rst_n(rst_n), .en_i(en),
        .hs_i(sync_w[0]), .vs_i(sync_w[1]), .de_i(act_w[0] && act_w[1]),
        .x_i(pos_w[0]), .y_i(pos_w[1]),
        .pol_i(act.pol), .fmt_i(fmt), .bg_i(bg),
        .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .x_o(x_o), .y_o(y_o), .rgb_o(rgb_o)
    );
endmodule

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        pix_valid_i = 1'b0;
    logic [23:0] pix_data_i = 24'd0;
    logic        hsync_o, vsync_o, de_o;
    logic [11:0] x_o, y_o;
    logic [23:0] rgb_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [23:0] bg_m = 24'hFF0000;

    always #2 clk = ~clk;

    lcd_timing_gen #(.DEF_W(8), .DEF_H(4)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .x_o(x_o), .y_o(y_o), .rgb_o(rgb_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    function automatic logic [23:0] fmt_m(input int f, input logic [23:0] c);
        logic [23:0] r;
        if (f == 3)      r = c;
        else if (f == 2) r = {6'b0, c[23:18], c[15:10], c[7:2]};
        else if (f == 1) r = {8'b0, c[23:19], c[15:10], c[7:3]};
        else             r = {12'b0, c[23:20], c[15:12], c[7:4]};
        return r;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Config B, committed mid-way through the first frame.
    localparam int BW = 4, BH = 2, BHS = 1, BHBP = 0, BHFP = 2, BVS = 2, BVBP = 1, BVFP = 0, BPOL = 7;

    task automatic run_frame(input int w, input int h, input int hs, input int hbp, input int hfp,
                             input int vs, input int vbp, input int vfp, input int pol,
                             input bit align, input bit inject);
        int ht, vt, tot, mid;
        ht = hs + hbp + w + hfp;
        vt = vs + vbp + h + vfp;
        tot = ht * vt;
        mid = tot / 2;
        if (!align) begin
            int guard = 0;
            do begin
                @(negedge clk);
                guard++;
            end while (vsync_o !== 1'b1 && guard < 1000);
        end else begin
            @(negedge clk);
        end
        for (int i = 0; i < tot; i++) begin
            int hc, vc, ex, ey;
            bit hsx, vsx, hd, vd, dex;
            logic [23:0] c;
            if (i > 0) @(negedge clk);
            hc = i % ht;
            vc = i / ht;
            hsx = hc < hs;
            vsx = vc < vs;
            hd = (hc >= hs + hbp) && (hc < hs + hbp + w);
            vd = (vc >= vs + vbp) && (vc < vs + vbp + h);
            dex = hd && vd;
            ex = dex ? hc - hs - hbp : 0;
            ey = dex ? vc - vs - vbp : 0;
            c = (dex && pix_valid_i) ? pix_data_i : bg_m;
            if (i == 0) chk(vsync_o == (1'b1 ^ pol[1]), "R3", "frame start on period boundary", vsync_o, 1'b1 ^ pol[1]);
            chk(hsync_o == (hsx ^ pol[0]), "R4 R8", "hsync", hsync_o, hsx ^ pol[0]);
            chk(vsync_o == (vsx ^ pol[1]), "R4 R8", "vsync", vsync_o, vsx ^ pol[1]);
            chk(de_o == (dex ^ pol[2]), "R5 R8", "de", de_o, dex ^ pol[2]);
            chk(x_o == 12'(ex), "R5", "x", x_o, ex);
            chk(y_o == 12'(ey), "R5", "y", y_o, ey);
            chk(rgb_o == c, "R6", "rgb", rgb_o, c);
            if (inject && i == mid + 6)
                chk(reg_rdata[5] == 1'b1, "R9", "GO pending reads 1", reg_rdata[5], 1);
            if (inject && i == mid + 7)
                chk(reg_rdata == ((BH - 1) << 16 | (BW - 1)), "R10", "shadow write while pending", reg_rdata, (BH - 1) << 16 | (BW - 1));
            reg_we = 1'b0;
            if (inject) begin
                case (i - mid)
                    0: begin reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h329; end
                    1: begin reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = (BH - 1) << 16 | (BW - 1); end
                    2: begin reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = BHBP << 20 | BHFP << 8 | BHS; end
                    3: begin reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = BVBP << 20 | BVFP << 8 | BVS; end
                    4: begin reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = BPOL; end
                    5: reg_addr = 3'd0;
                    6: reg_addr = 3'd1;
                    default: ;
                endcase
            end
            pix_valid_i = ((i + 1) % 3) != 2;
            pix_data_i  = 24'((i + 1) * 32'h010305) ^ 24'h5A5A5A;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        rd(3'd0, d); chk(d == 32'h0, "R1", "ctrl reset", d, 0);
        rd(3'd1, d); chk(d == 32'h0003_0007, "R1", "size reset", d, 32'h0003_0007);
        rd(3'd2, d); chk(d == (47 << 20 | 15 << 8 | 95), "R1", "htim reset", d, 47 << 20 | 15 << 8 | 95);
        rd(3'd3, d); chk(d == (32 << 20 | 9 << 8 | 2), "R1", "vtim reset", d, 32 << 20 | 9 << 8 | 2);
        rd(3'd4, d); chk(d == 32'h0, "R1", "pol reset", d, 0);
        rd(3'd5, d); chk(d == 32'h00FF0000, "R1", "bg reset", d, 32'h00FF0000);
        chk({hsync_o, vsync_o, de_o} == 3'b000, "R11", "idle outputs after reset", {hsync_o, vsync_o, de_o}, 0);
        chk(rgb_o == 24'h000F00, "R7", "12-bit packed background at reset", rgb_o, 24'h000F00);

        // Config A, committed while disabled
        wr(3'd1, 2 << 16 | 5);
        wr(3'd2, 3 << 20 | 1 << 8 | 2);
        wr(3'd3, 2 << 20 | 1 << 8 | 1);
        wr(3'd4, 0);
        rd(3'd2, d); chk(d == (3 << 20 | 1 << 8 | 2), "R2", "htim readback", d, 3 << 20 | 1 << 8 | 2);
        rd(3'd1, d); chk(d == (2 << 16 | 5), "R2", "size readback", d, 2 << 16 | 5);
        wr(3'd0, 32'h20);
        rd(3'd0, d); chk(d[5] == 1'b1, "R9", "GO set by write", d[5], 1);
        @(negedge clk);
        rd(3'd0, d); chk(d[5] == 1'b0, "R11", "GO completes at once when disabled", d[5], 0);

        wr(3'd0, 32'h309);
        rd(3'd0, d); chk(d == 32'h309, "R7", "ctrl enable/tft/format readback", d, 32'h309);
        run_frame(6, 3, 2, 3, 1, 1, 2, 1, 0, 1'b0, 1'b1);
        run_frame(BW, BH, BHS, BHBP, BHFP, BVS, BVBP, BVFP, BPOL, 1'b1, 1'b0);
        run_frame(BW, BH, BHS, BHBP, BHFP, BVS, BVBP, BVFP, BPOL, 1'b1, 1'b0);
        rd(3'd0, d); chk(d[5] == 1'b0, "R9", "GO cleared by hardware after commit", d[5], 0);

        // Disabled: idle levels under inverted polarity
        wr(3'd0, 32'h0);
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk({hsync_o, vsync_o, de_o} == 3'b111, "R11", "inactive levels (inverted)", {hsync_o, vsync_o, de_o}, 3'b111);
            chk(x_o == 0 && y_o == 0, "R11", "coords held", {x_o, y_o}, 0);
        end

        // Packing modes with a live background colour
        for (int f = 0; f < 4; f++) begin
            bg_m = (f % 2 == 0) ? 24'hA5C3E7 : 24'h123456;
            wr(3'd5, {8'h0, bg_m});
            wr(3'd0, f << 8);
            chk(rgb_o == fmt_m(f, bg_m), "R7", "packed background", rgb_o, fmt_m(f, bg_m));
            chk(rgb_o == fmt_m(f, bg_m), "R6", "background takes effect at once", rgb_o, fmt_m(f, bg_m));
        end
        summary();
    end
endmodule